// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block puts a small microcontroller core to sleep and wakes it up again. Software first writes a control register that holds a sleep-enable bit and a 3-bit mode code. When the core then reports that it has executed its sleep instruction, the block closes the clock enables that the chosen mode calls for and holds the core halted. It then waits for an enabled interrupt or for a reset request.

The mode code is sorted into three classes. The light mode stops only the CPU and flash clocks. The I/O clock, which feeds the peripherals, timers, serial units and interrupt logic, keeps running. The deep modes stop all three clock enables, and only the always-on wake-detect logic in this block stays clocked. Each deep class has its own start-up wait, set by a parameter, so that the oscillator can settle before the clocks are opened again.

The two wake sources follow different paths. An interrupt wake runs the start-up wait and then a fixed halt of four cycles. After that it gives a one-cycle pulse that tells the core to continue at the instruction after the sleep instruction. A reset wake runs only the start-up wait and then gives a one-cycle pulse that sends the core to its reset vector. The block has no clear or reset path toward the register file or the data memory.

Top module: `slpctl_top`

## Requirements
- R1: After the synchronous reset, all three clock enables are 1, core_halt is 0, the enable bit and mode readback are 0, slp_flag is 0, and neither resume pulse is high.
- R2: Sleep is entered only on a cycle where sleep_strobe is 1 and the stored enable bit is 1. A strobe while the enable bit is 0 leaves core_halt at 0 and all clocks on.
- R3: A write with ctl_we stores ctl_wdata bit 0 as the enable bit and bits 3:1 as the mode code, and both read back on ctl_en and ctl_mode in the next cycle.
- R4: Mode 000 and the unused codes 001, 100 and 101 behave as the light mode. While asleep, clk_en_cpu and clk_en_flash are 0 and clk_en_io is 1, and there is no start-up wait.
- R5: Codes 010, 011, 110 and 111 are deep modes and turn off all three clock enables while asleep. Code 010 waits STARTUP_LONG cycles after a wake. The other three wait STARTUP_SHORT cycles.
- R6: Only a pending interrupt whose enable bit is also set (irq_pend & irq_en) wakes the block. Pending interrupts that are masked leave it asleep.
- R7: After an interrupt wake, core_halt stays 1 for the start-up wait plus 4 cycles. During those 4 cycles clk_en_cpu is 0 and the flash and I/O clocks are 1. Then resume_next is high for exactly one cycle, with core_halt at 0 and all clocks on.
- R8: A wake_rst_req while asleep wakes the block. After the start-up wait, with no 4-cycle halt, reset_vec pulses for one cycle and resume_next stays 0. A reset request wins over an interrupt that arrives in the same cycle. A reset request while the block is active has no effect.
- R9: If a wake-causing interrupt is present in the same cycle as an accepted sleep strobe, entry into sleep is aborted. core_halt stays 0 and slp_flag is not set.
- R10: slp_flag is set when sleep is entered and stays set after the wake. Any register write clears it, unless sleep is being entered in that same cycle, in which case setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Write data: bit 0 is the enable bit, bits 3:1 are the mode code |
| sleep_strobe | input | 1 | Core has executed its sleep instruction |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| irq_en | input | IRQ_W | Interrupt enable mask |
| wake_rst_req | input | 1 | Reset request from the reset sources |
| ctl_en | output | 1 | Stored enable bit |
| ctl_mode | output | 3 | Stored mode code |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Flash clock enable |
| clk_en_io | output | 1 | Peripheral, timer, serial and interrupt clock enable |
| core_halt | output | 1 | Core is held stopped |
| resume_next | output | 1 | One-cycle pulse: continue after the sleep instruction |
| reset_vec | output | 1 | One-cycle pulse: restart from the reset vector |
| slp_flag | output | 1 | Sleep has been entered since the last register write |

## Verification
If the sequencer is in the wrong state, the clock enables show it on the very next cycle: the CPU or I/O enable opens while asleep, or stays shut while the core is active. A wrong start-up or halt counter does not show while the core is asleep. It shows only as a resume or reset-vector pulse that comes too early or too late, so the bench counts cycles from the wake edge to the pulse in every mode class and on both wake paths. A wrongly recorded wake kind shows up as the wrong one of the two pulses.

// File: rtl/slpctl_pkg.sv
package slpctl_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_SLEEP,
        ST_STARTUP,
        ST_HALT4,
        ST_RESUME
    } slp_state_e;

    typedef enum logic [1:0] {
        MC_LIGHT,
        MC_DEEP_LONG,
        MC_DEEP_SHORT
    } mode_class_e;

    typedef enum logic {
        WK_IRQ,
        WK_RST
    } wake_kind_e;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
    } clk_en_t;

    localparam int unsigned HALT_CYCLES = 4;

    function automatic mode_class_e classify_mode(input logic [2:0] code);
        mode_class_e c;
        case (code)
            3'b010:                 c = MC_DEEP_LONG;
            3'b011, 3'b110, 3'b111: c = MC_DEEP_SHORT;
            default:                c = MC_LIGHT;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/slpctl_mode_dec.sv
module slpctl_mode_dec
    import slpctl_pkg::*;
#(
    parameter int unsigned STARTUP_LONG  = 16,
    parameter int unsigned STARTUP_SHORT = 6,
    parameter int unsigned CNT_W         = 5
) (
    input  mode_class_e      cls,
    output logic [CNT_W-1:0] delay,
    output clk_en_t          asleep_gate
);

    always_comb begin
        case (cls)
            MC_DEEP_LONG: begin
                delay       = CNT_W'(STARTUP_LONG);
                asleep_gate = '{cpu: 1'b0, flash: 1'b0, io: 1'b0};
            end
            MC_DEEP_SHORT: begin
                delay       = CNT_W'(STARTUP_SHORT);
                asleep_gate = '{cpu: 1'b0, flash: 1'b0, io: 1'b0};
            end
            default: begin
                delay       = '0;
                asleep_gate = '{cpu: 1'b0, flash: 1'b0, io: 1'b1};
            end
        endcase
    end

endmodule

// File: rtl/slpctl_fsm.sv
module slpctl_fsm
    import slpctl_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_go,
    input  logic             irq_wake,
    input  logic             rst_wake,
    input  mode_class_e      mode_cls,
    input  logic [CNT_W-1:0] delay,
    output slp_state_e       state_q,
    output mode_class_e      cls_q,
    output wake_kind_e       kind_q,
    output logic             sleep_enter
);

    localparam int unsigned HW = $clog2(HALT_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic [HW-1:0]    hcnt_q;

    assign sleep_enter = (state_q == ST_ACTIVE) && sleep_go && !irq_wake;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACTIVE;
            cls_q   <= MC_LIGHT;
            kind_q  <= WK_IRQ;
            cnt_q   <= '0;
            hcnt_q  <= '0;
        end else begin
            case (state_q)
                ST_ACTIVE: begin
                    if (sleep_enter) begin
                        state_q <= ST_SLEEP;
                        cls_q   <= mode_cls;
                    end
                end
                ST_SLEEP: begin
                    if (rst_wake) begin
                        kind_q  <= WK_RST;
                        cnt_q   <= delay;
                        state_q <= (delay != '0) ? ST_STARTUP : ST_RESUME;
                    end else if (irq_wake) begin
                        kind_q  <= WK_IRQ;
                        cnt_q   <= delay;
                        hcnt_q  <= '0;
                        state_q <= (delay != '0) ? ST_STARTUP : ST_HALT4;
                    end
                end
                ST_STARTUP: begin
                    if (cnt_q == CNT_W'(1)) begin
                        hcnt_q  <= '0;
                        state_q <= (kind_q == WK_RST) ? ST_RESUME : ST_HALT4;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_HALT4: begin
                    if (hcnt_q == HW'(HALT_CYCLES - 1)) begin
                        state_q <= ST_RESUME;
                    end else begin
                        hcnt_q <= hcnt_q + HW'(1);
                    end
                end
                default: state_q <= ST_ACTIVE;
            endcase
        end
    end

    AST_NO_ENTRY_WITHOUT_GO: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && !sleep_go) |=> (state_q == ST_ACTIVE)); // R2

    AST_MASKED_STAYS_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && !irq_wake && !rst_wake) |=> (state_q == ST_SLEEP)); // R6

    AST_HALT_FOUR_CYCLES: assert property (@(posedge clk) disable iff (rst)
        $fell(state_q == ST_HALT4) |-> $past(state_q == ST_HALT4, 4)); // R7

    AST_ABORT_ON_WAKE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && irq_wake) |=> (state_q == ST_ACTIVE)); // R9

endmodule

// File: rtl/slpctl_clk_gate.sv
module slpctl_clk_gate
    import slpctl_pkg::*;
(
    input  slp_state_e state,
    input  clk_en_t    asleep_gate,
    output clk_en_t    clk_en
);

    always_comb begin
        case (state)
            ST_SLEEP, ST_STARTUP: clk_en = asleep_gate;
            ST_HALT4:             clk_en = '{cpu: 1'b0, flash: 1'b1, io: 1'b1};
            default:              clk_en = '{cpu: 1'b1, flash: 1'b1, io: 1'b1};
        endcase
    end

endmodule

// File: rtl/slpctl_top.sv
module slpctl_top
    import slpctl_pkg::*;
#(
    parameter int unsigned IRQ_W         = 8,
    parameter int unsigned STARTUP_LONG  = 16,
    parameter int unsigned STARTUP_SHORT = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [3:0]       ctl_wdata,
    input  logic             sleep_strobe,
    input  logic [IRQ_W-1:0] irq_pend,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic             wake_rst_req,
    output logic             ctl_en,
    output logic [2:0]       ctl_mode,
    output logic             clk_en_cpu,
    output logic             clk_en_flash,
    output logic             clk_en_io,
    output logic             core_halt,
    output logic             resume_next,
    output logic             reset_vec,
    output logic             slp_flag
);

    localparam int unsigned MAX_DLY = (STARTUP_LONG > STARTUP_SHORT) ? STARTUP_LONG : STARTUP_SHORT;
    localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);

    logic             en_q;
    logic [2:0]       mode_q;
    logic             flag_q;
    logic             irq_wake;
    logic             sleep_enter;
    slp_state_e       state;
    mode_class_e      cls_q;
    wake_kind_e       kind_q;
    logic [CNT_W-1:0] delay;
    clk_en_t          asleep_gate;
    clk_en_t          clk_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            mode_q <= 3'b000;
            flag_q <= 1'b0;
        end else begin
            if (ctl_we) begin
                en_q   <= ctl_wdata[0];
                mode_q <= ctl_wdata[3:1];
            end
            if (sleep_enter) begin
                flag_q <= 1'b1;
            end else if (ctl_we) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign irq_wake = |(irq_pend & irq_en);

    slpctl_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sleep_go    (sleep_strobe && en_q),
        .irq_wake    (irq_wake),
        .rst_wake    (wake_rst_req),
        .mode_cls    (classify_mode(mode_q)),
        .delay       (delay),
        .state_q     (state),
        .cls_q       (cls_q),
        .kind_q      (kind_q),
        .sleep_enter (sleep_enter)
    );

    slpctl_mode_dec #(
        .STARTUP_LONG  (STARTUP_LONG),
        .STARTUP_SHORT (STARTUP_SHORT),
        .CNT_W         (CNT_W)
    ) u_dec (
        .cls         (cls_q),
        .delay       (delay),
        .asleep_gate (asleep_gate)
    );

    slpctl_clk_gate u_gate (
        .state       (state),
        .asleep_gate (asleep_gate),
        .clk_en      (clk_en)
    );

    assign ctl_en       = en_q;
    assign ctl_mode     = mode_q;
    assign slp_flag     = flag_q;
    assign clk_en_cpu   = clk_en.cpu;
    assign clk_en_flash = clk_en.flash;
    assign clk_en_io    = clk_en.io;
    assign core_halt    = (state == ST_SLEEP) || (state == ST_STARTUP) || (state == ST_HALT4);
    assign resume_next  = (state == ST_RESUME) && (kind_q == WK_IRQ);
    assign reset_vec    = (state == ST_RESUME) && (kind_q == WK_RST);

    AST_HALT_GATES_CPU: assert property (@(posedge clk) disable iff (rst)
        core_halt |-> !clk_en_cpu); // R7

    AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (resume_next || reset_vec) |=> !(resume_next || reset_vec) && !core_halt); // R7

    AST_FLAG_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(core_halt) |-> slp_flag); // R10

    AST_SINGLE_RESUME_KIND: assert property (@(posedge clk) disable iff (rst)
        !(resume_next && reset_vec)); // R8

endmodule

// File: tb/slpctl_top_tb.sv
module slpctl_top_tb;

    localparam int unsigned IRQ_W = 8;
    localparam int unsigned LONGD = 16;
    localparam int unsigned SHORTD = 6;

    logic             clk = 1'b0;
    logic             rst;
    logic             ctl_we;
    logic [3:0]       ctl_wdata;
    logic             sleep_strobe;
    logic [IRQ_W-1:0] irq_pend;
    logic [IRQ_W-1:0] irq_en;
    logic             wake_rst_req;
    logic             ctl_en;
    logic [2:0]       ctl_mode;
    logic             clk_en_cpu, clk_en_flash, clk_en_io;
    logic             core_halt, resume_next, reset_vec, slp_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    slpctl_top #(.IRQ_W(IRQ_W), .STARTUP_LONG(LONGD), .STARTUP_SHORT(SHORTD)) u_dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .sleep_strobe(sleep_strobe), .irq_pend(irq_pend), .irq_en(irq_en),
        .wake_rst_req(wake_rst_req), .ctl_en(ctl_en), .ctl_mode(ctl_mode),
        .clk_en_cpu(clk_en_cpu), .clk_en_flash(clk_en_flash), .clk_en_io(clk_en_io),
        .core_halt(core_halt), .resume_next(resume_next), .reset_vec(reset_vec),
        .slp_flag(slp_flag)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic write_ctl(input logic en, input logic [2:0] mode);
        ctl_we = 1'b1;
        ctl_wdata = {mode, en};
        tick();
        ctl_we = 1'b0;
    endtask

    task automatic enter_sleep(input logic [2:0] mode);
        write_ctl(1'b1, mode);
        sleep_strobe = 1'b1;
        tick();
        sleep_strobe = 1'b0;
    endtask

    // counts cycles after the wake edge until a resume pulse shows
    task automatic wait_pulse(output int n);
        n = 0;
        while (!(resume_next || reset_vec) && n < 200) begin
            tick();
            n++;
        end
    endtask

    task automatic t_reset();
        chk("R1 cpu en", clk_en_cpu, 1);
        chk("R1 flash en", clk_en_flash, 1);
        chk("R1 io en", clk_en_io, 1);
        chk("R1 halt", core_halt, 0);
        chk("R1 ctl_en", ctl_en, 0);
        chk("R1 ctl_mode", ctl_mode, 0);
        chk("R1 flag", slp_flag, 0);
        chk("R1 pulses", resume_next | reset_vec, 0);
    endtask

    task automatic t_register();
        write_ctl(1'b1, 3'b110);
        chk("R3 en readback", ctl_en, 1);
        chk("R3 mode readback", ctl_mode, 6);
        write_ctl(1'b0, 3'b011);
        chk("R3 en cleared", ctl_en, 0);
        chk("R3 mode readback 2", ctl_mode, 3);
    endtask

    task automatic t_no_enable();
        write_ctl(1'b0, 3'b010);
        sleep_strobe = 1'b1;
        tick();
        sleep_strobe = 1'b0;
        chk("R2 strobe without enable halt", core_halt, 0);
        chk("R2 strobe without enable io", clk_en_io, 1);
        tick();
        chk("R2 still active", core_halt, 0);
    endtask

    task automatic t_light_irq(input logic [2:0] mode, input string tag);
        int n;
        enter_sleep(mode);
        chk({tag, " halt"}, core_halt, 1);
        chk({tag, " cpu off"}, clk_en_cpu, 0);
        chk({tag, " flash off"}, clk_en_flash, 0);
        chk({tag, " io on"}, clk_en_io, 1);
        chk("R10 flag set", slp_flag, 1);
        irq_pend = 8'h10;
        irq_en = 8'h01;
        repeat (3) tick();
        chk("R6 masked irq keeps sleep", core_halt, 1);
        chk("R6 masked irq no pulse", resume_next, 0);
        irq_en = 8'h10;
        tick();
        irq_pend = '0;
        irq_en = '0;
        chk("R7 halt phase cpu off", clk_en_cpu, 0);
        chk("R7 halt phase flash on", clk_en_flash, 1);
        chk("R7 halt phase io on", clk_en_io, 1);
        wait_pulse(n);
        chk({tag, " R7 light wake cycles"}, n, 4);
        chk("R7 resume_next", resume_next, 1);
        chk("R7 halt released", core_halt, 0);
        chk("R7 cpu on at resume", clk_en_cpu, 1);
        chk("R7 no reset_vec", reset_vec, 0);
        tick();
        chk("R7 pulse one cycle", resume_next, 0);
        chk("R10 flag kept after wake", slp_flag, 1);
        write_ctl(1'b0, 3'b000);
        chk("R10 flag cleared by write", slp_flag, 0);
    endtask

    task automatic t_deep_irq(input logic [2:0] mode, input int dly);
        int n;
        enter_sleep(mode);
        chk("R5 deep cpu off", clk_en_cpu, 0);
        chk("R5 deep flash off", clk_en_flash, 0);
        chk("R5 deep io off", clk_en_io, 0);
        irq_pend = 8'h80;
        irq_en = 8'h80;
        tick();
        irq_pend = '0;
        irq_en = '0;
        chk("R5 io off during startup", clk_en_io, (dly > 0) ? 0 : 1);
        wait_pulse(n);
        chk("R5 R7 deep wake cycles", n, dly + 4);
        chk("R7 resume_next deep", resume_next, 1);
        tick();
        write_ctl(1'b0, 3'b000);
    endtask

    task automatic t_rst_wake();
        int n;
        enter_sleep(3'b011);
        wake_rst_req = 1'b1;
        tick();
        wake_rst_req = 1'b0;
        wait_pulse(n);
        chk("R8 reset wake cycles", n, SHORTD);
        chk("R8 reset_vec", reset_vec, 1);
        chk("R8 no resume_next", resume_next, 0);
        tick();
        chk("R8 pulse one cycle", reset_vec, 0);
        // reset and interrupt together in light mode: reset wins
        enter_sleep(3'b000);
        wake_rst_req = 1'b1;
        irq_pend = 8'h01;
        irq_en = 8'h01;
        tick();
        wake_rst_req = 1'b0;
        irq_pend = '0;
        irq_en = '0;
        chk("R8 priority reset_vec", reset_vec, 1);
        chk("R8 priority resume_next", resume_next, 0);
        tick();
        // reset request while active
        wake_rst_req = 1'b1;
        tick();
        wake_rst_req = 1'b0;
        chk("R8 active reset ignored pulse", reset_vec, 0);
        chk("R8 active reset ignored halt", core_halt, 0);
        write_ctl(1'b0, 3'b000);
    endtask

    task automatic t_abort();
        write_ctl(1'b1, 3'b010);
        irq_pend = 8'h02;
        irq_en = 8'h02;
        sleep_strobe = 1'b1;
        tick();
        sleep_strobe = 1'b0;
        irq_pend = '0;
        irq_en = '0;
        chk("R9 abort halt", core_halt, 0);
        chk("R9 abort flag", slp_flag, 0);
        chk("R9 abort io on", clk_en_io, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        ctl_we = 1'b0;
        ctl_wdata = '0;
        sleep_strobe = 1'b0;
        irq_pend = '0;
        irq_en = '0;
        wake_rst_req = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_register();
        t_no_enable();
        t_light_irq(3'b000, "R4 idle");
        t_light_irq(3'b101, "R4 reserved 101");
        t_light_irq(3'b001, "R4 reserved 001");
        t_deep_irq(3'b010, LONGD);
        t_deep_irq(3'b111, SHORTD);
        t_deep_irq(3'b110, SHORTD);
        t_rst_wake();
        t_abort();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule